// File: doc/BRIEF.md
# Class G Supply Rail Selector

This block decides which of two supply levels powers a stereo headphone output stage. Each clock cycle it takes a signed digital estimate of the output amplitude for the left and the right channel. It forms the larger of the two magnitudes and compares that value against two programmable levels.

When the magnitude reaches the up-switch level, the selector moves to the high rail on the next clock edge. It returns to the low rail only after the magnitude has stayed at or below a separate down-switch level for a programmable number of timing ticks. This asymmetry lets the output stage follow peaks at once while running from the low rail most of the time.

The one-bit output drives the regulator setpoint: 0 selects the low rail (about 1.1 V) and 1 selects the high rail (about 1.8 V). A shutdown input, like reset, forces the low rail.

Top module: `rail_sel`

## Requirements
- R1: While reset is asserted or `shutdown` is 1, `rail_hi` is 0 and the quiet-tick count is cleared. After a shutdown, a later release needs the full hold count again.
- R2: The decision magnitude is the larger of the absolute values of `samp_l` and `samp_r`, both two's complement. The most negative sample has magnitude 2^(W-1).
- R3: A cycle with magnitude >= `up_thr` and `shutdown` at 0 sets `rail_hi` to 1 at the next clock edge, whatever the value of `tick`.
- R4: While on the high rail, any cycle with magnitude > `dn_thr` clears the quiet-tick count, including a cycle without a tick.
- R5: On the high rail, a cycle with `tick` at 1 and magnitude <= `dn_thr` counts as a quiet tick. The rail drops at the edge of the quiet tick that completes `hold_ticks` consecutive quiet ticks. A `hold_ticks` value of 0 acts as 1. Quiet cycles without a tick do not count.
- R6: On the low rail, a magnitude below `up_thr` keeps `rail_hi` at 0, even when it is above `dn_thr`.
- R7: `shutdown` overrides an up-switch in the same cycle.
- R8: On the high rail, a magnitude between `dn_thr` (exclusive) and `up_thr` (exclusive) holds the high rail for any number of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shutdown | input | 1 | Forces the low rail and clears the hold count |
| tick | input | 1 | Clock-enable pulse that times the release hold |
| samp_l | input | W | Left amplitude estimate, signed |
| samp_r | input | W | Right amplitude estimate, signed |
| up_thr | input | W | Magnitude at or above which the high rail is selected |
| dn_thr | input | W | Magnitude at or below which a tick counts as quiet |
| hold_ticks | input | CW | Quiet ticks required before returning to the low rail |
| rail_hi | output | 1 | Rail select: 0 low, 1 high |

## Verification
The hardest case to reach from the ports is a hold window that is interrupted. The selector must be on the high rail with part of the quiet count already built up. Then a single loud cycle arrives without a tick, or a shutdown pulse arrives, and only the extended release time shows that the count was cleared. The stimulus builds this case one cycle at a time. Ticks and samples are driven together, a fixed number of quiet ticks is placed before the interruption, and the rail is checked one tick before and exactly at the expected release edge.

// File: rtl/rail_sel.sv
module rail_sel #(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shutdown,
  input  logic                tick,
  input  logic signed [W-1:0] samp_l,
  input  logic signed [W-1:0] samp_r,
  input  logic        [W-1:0] up_thr,
  input  logic        [W-1:0] dn_thr,
  input  logic       [CW-1:0] hold_ticks,
  output logic                rail_hi
);
  localparam int NW = CW + 1;

  logic [W-1:0]  mag_l, mag_r, mag;
  logic [CW-1:0] qcnt;
  logic [NW-1:0] qnext;
  logic          up_hit, quiet, done;

  assign mag_l  = samp_l[W-1] ? W'(~samp_l + 1'b1) : W'(samp_l);
  assign mag_r  = samp_r[W-1] ? W'(~samp_r + 1'b1) : W'(samp_r);
  assign mag    = (mag_l > mag_r) ? mag_l : mag_r;
  assign up_hit = mag >= up_thr;
  assign quiet  = mag <= dn_thr;
  assign qnext  = {1'b0, qcnt} + NW'(1);
  assign done   = qnext >= {1'b0, hold_ticks};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rail_hi <= 1'b0;
      qcnt    <= '0;
    end else if (shutdown) begin
      rail_hi <= 1'b0;
      qcnt    <= '0;
    end else if (up_hit) begin
      rail_hi <= 1'b1;
      qcnt    <= '0;
    end else if (!rail_hi || !quiet) begin
      qcnt <= '0;
    end else if (tick) begin
      if (done) begin
        rail_hi <= 1'b0;
        qcnt    <= '0;
      end else begin
        qcnt <= qnext[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/rail_sel_chk.sv
module rail_sel_chk #(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                shutdown,
  input logic                tick,
  input logic signed [W-1:0] samp_l,
  input logic signed [W-1:0] samp_r,
  input logic        [W-1:0] up_thr,
  input logic        [W-1:0] dn_thr,
  input logic       [CW-1:0] hold_ticks,
  input logic                rail_hi
);
  logic [W-1:0] al, ar, pk;
  assign al = (samp_l < 0) ? W'(-samp_l) : W'(samp_l);
  assign ar = (samp_r < 0) ? W'(-samp_r) : W'(samp_r);
  assign pk = (al >= ar) ? al : ar;

  assert_shutdown_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !rail_hi);
  assert_up_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && pk >= up_thr) |=> rail_hi);
  assert_rise_needs_peak_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_hi) |-> $past(pk) >= $past(up_thr));
  assert_fall_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rail_hi) && !$past(shutdown)) |-> ($past(tick) && $past(pk) <= $past(dn_thr)));
  assert_hold_above_dn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_hi && !shutdown && pk > dn_thr) |=> rail_hi);
  assert_low_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rail_hi && pk < up_thr) |=> !rail_hi);
endmodule

bind rail_sel rail_sel_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .tick(tick),
  .samp_l(samp_l), .samp_r(samp_r), .up_thr(up_thr), .dn_thr(dn_thr),
  .hold_ticks(hold_ticks), .rail_hi(rail_hi)
);

// File: tb/tb_rail_sel.sv
module tb_rail_sel;
  localparam int W = 16, CW = 16;
  logic clk = 0, rst_n = 0, shutdown = 0, tick = 0;
  logic signed [W-1:0] samp_l = 0, samp_r = 0;
  logic [W-1:0] up_thr = 16'd1000, dn_thr = 16'd400;
  logic [CW-1:0] hold_ticks = 16'd4;
  logic rail_hi;
  int errors = 0, checks = 0;
  bit done = 0;

  rail_sel #(.W(W), .CW(CW)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input logic exp, input string req);
    checks++;
    if (rail_hi !== exp) begin
      errors++;
      $display("FAIL %s: rail_hi=%0b expected %0b at %0t", req, rail_hi, exp, $time);
    end
  endtask

  task automatic cyc(input int l, input int r, input logic tk, input logic sd = 0);
    samp_l = W'(l); samp_r = W'(r); tick = tk; shutdown = sd;
    @(negedge clk);
  endtask

  task automatic go_high();
    cyc(2000, 0, 0); chk(1, "R3 setup");
  endtask

  task automatic t_reset();
    chk(0, "R1 reset");
  endtask

  task automatic t_up();
    cyc(999, 0, 1); chk(0, "R6 below up");
    cyc(1000, 0, 0); chk(1, "R3 equal up no tick");
    cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1); chk(1, "R5 three quiet");
    cyc(0, 0, 1); chk(0, "R5 fourth quiet release");
  endtask

  task automatic t_no_tick();
    go_high();
    for (int i = 0; i < 10; i++) cyc(0, 0, 0);
    chk(1, "R5 quiet w/o tick ignored");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1);
    chk(0, "R5 release");
  endtask

  task automatic t_restart();
    go_high();
    cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 500, 0);
    cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1); chk(1, "R4 restarted count");
    cyc(0, 0, 1); chk(0, "R4 release after restart");
  endtask

  task automatic t_neg();
    cyc(0, -1000, 0); chk(1, "R2 negative right");
    for (int i = 0; i < 4; i++) cyc(-400, 400, 1);
    chk(0, "R5 quiet at dn level");
    up_thr = 16'd32768;
    cyc(32767, -32767, 0); chk(0, "R2 below most negative");
    cyc(100, -32768, 0); chk(1, "R2 most negative");
    up_thr = 16'd1000;
    for (int i = 0; i < 4; i++) cyc(0, 0, 1);
    chk(0, "R5 release");
  endtask

  task automatic t_stay_low();
    for (int i = 0; i < 8; i++) cyc(999, -999, 1);
    chk(0, "R6 between levels stays low");
  endtask

  task automatic t_hyst();
    go_high();
    for (int i = 0; i < 20; i++) cyc(700, -401, 1);
    chk(1, "R8 hysteresis holds high");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1);
    chk(0, "R5 release");
  endtask

  task automatic t_shdn();
    cyc(2000, 2000, 1, 1); chk(0, "R7 shutdown overrides");
    cyc(2000, 0, 0, 0); chk(1, "R7 after shutdown");
    cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1);
    cyc(0, 0, 0, 1); chk(0, "R1 shutdown low");
    go_high();
    cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1); chk(1, "R1 count cleared");
    cyc(0, 0, 1); chk(0, "R1 full hold release");
  endtask

  task automatic t_hold0();
    hold_ticks = 0;
    go_high();
    cyc(0, 0, 0); chk(1, "R5 hold0 no tick");
    cyc(0, 0, 1); chk(0, "R5 hold0 first tick");
    hold_ticks = 4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_up();
    t_no_tick();
    t_restart();
    t_neg();
    t_stay_low();
    t_hyst();
    t_shdn();
    t_hold0();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule